// File: doc/BRIEF.md
# Requester-ID to Stream-ID Translation Table

This block maps the 16-bit requester ID of an inbound PCIe transaction to a 6-bit stream ID and a 3-bit auxiliary ID. An IOMMU and an interrupt translation service downstream use these IDs to tag the transaction. The table has 32 entries. Each entry holds a valid flag, a stored requester ID, a per-bit match mask, a stream ID and an auxiliary ID. A lookup presents a requester ID and receives the registered hit flag and IDs one clock later. When several entries match, the lowest-numbered entry wins.

Software reaches the table only indirectly, through a strobe-driven register port with three registers.

- **Control register (address 0):** holds an entry index and an action bit.
- **Staging register A (address 1):** holds the valid flag, auxiliary ID and stream ID of one entry.
- **Staging register B (address 2):** holds the requester ID and match mask of one entry.

Writing the control register with the action bit set copies the indexed entry into the two staging registers, so it can be read back. Writing it with the action bit clear stores the staging registers into the indexed entry.

Top module: `reqid_stream_map`

## Requirements
- R1: After reset every entry is invalid, every lookup misses, and all four register addresses read zero.
- R2: A control write with bit 16 set loads the entry at index bits 4:0 into both staging registers and leaves the table unchanged. The staging registers change only on a register write.
- R3: A control write with bit 16 clear stores the present staging contents into the entry at index bits 4:0.
- R4: Staging register A keeps the valid flag in bit 31, the auxiliary ID in bits 10:8 and the stream ID in bits 5:0. All other bits read zero, so a stream ID of 64 or more keeps only its low 6 bits.
- R5: Staging register B keeps the requester ID in bits 31:16 and the match mask in bits 15:0, and reads back all 32 bits as written.
- R6: An entry hits when it is valid and the incoming requester ID equals the stored requester ID in every bit where the mask is 1. An all-ones mask therefore matches one exact ID, and a zero mask matches every ID.
- R7: When several valid entries hit, the lookup returns the IDs of the lowest-numbered entry.
- R8: On a miss, lk_hit is 0 and both lk_sid and lk_aux are 0.
- R9: The lookup result appears one clock after lk_rid is presented. A lookup presented in the same cycle as a store write sees the old entry, and a lookup presented in the following cycle sees the new entry.
- R10: Storing zero in both staging registers into an index invalidates that entry.
- R11: The control register reads back the index in bits 4:0 and the action bit in bit 16, with all other bits zero. Address 3 reads zero, and writes to it change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select: 0 control, 1 staging A, 2 staging B, 3 unused |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data of the selected register (combinational) |
| lk_rid | input | 16 | Requester ID to translate |
| lk_hit | output | 1 | Registered hit flag |
| lk_sid | output | 6 | Registered stream ID |
| lk_aux | output | 3 | Registered auxiliary ID |

## Verification
A corrupted entry or a wrong priority shows up one clock after the affected requester ID is presented, as a wrong hit flag or wrong IDs. A lookup that matches a higher-numbered entry instead of the lowest is exposed by deliberately overlapping masks. A staging register that drifts or loads from the wrong index appears at once on reg_rdata after a read-action write. A store that lands late or at the wrong index is caught by a lookup issued in the same cycle as the store and in the cycle after it.

// File: rtl/rsm_pkg.sv
package rsm_pkg;

    localparam int REG_W       = 32;
    localparam int RID_W       = 16;
    localparam int SID_W       = 6;
    localparam int AUX_W       = 3;
    localparam int IDX_FIELD_W = 5;
    localparam int ACT_BIT     = 16;

    typedef enum logic [1:0] {
        SEL_CTRL   = 2'd0,
        SEL_DATA_A = 2'd1,
        SEL_DATA_B = 2'd2,
        SEL_NONE   = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic             vld;
        logic [AUX_W-1:0] aux;
        logic [SID_W-1:0] sid;
        logic [RID_W-1:0] key;
        logic [RID_W-1:0] mask;
    } entry_t;

    typedef struct packed {
        logic             hit;
        logic [SID_W-1:0] sid;
        logic [AUX_W-1:0] aux;
    } result_t;

    function automatic logic [REG_W-1:0] image_a(entry_t e);
        return {e.vld, 20'b0, e.aux, 2'b0, e.sid};
    endfunction

    function automatic logic [REG_W-1:0] image_b(entry_t e);
        return {e.key, e.mask};
    endfunction

endpackage

// File: rtl/rsm_regs.sv
module rsm_regs
    import rsm_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr,
    input  logic [1:0]             addr,
    input  logic [REG_W-1:0]       wdata,
    input  entry_t                 peek_entry,
    output logic [IDX_FIELD_W-1:0] peek_idx,
    output logic                   commit_en,
    output logic [IDX_FIELD_W-1:0] commit_idx,
    output entry_t                 commit_entry,
    output entry_t                 stage,
    output logic [REG_W-1:0]       rdata
);

    typedef struct packed {
        logic [IDX_FIELD_W-1:0] idx;
        logic                   act;
        entry_t                 stg;
    } regs_t;

    regs_t    st_d, st_q;
    reg_sel_e sel;
    logic     commit_d;

    assign sel        = reg_sel_e'(addr);
    assign peek_idx   = wdata[IDX_FIELD_W-1:0];
    assign commit_idx = wdata[IDX_FIELD_W-1:0];

    always_comb begin
        st_d     = st_q;
        commit_d = 1'b0;
        if (wr) begin
            case (sel)
                SEL_CTRL: begin
                    st_d.idx = wdata[IDX_FIELD_W-1:0];
                    st_d.act = wdata[ACT_BIT];
                    if (wdata[ACT_BIT]) begin
                        st_d.stg = peek_entry;
                    end else begin
                        commit_d = 1'b1;
                    end
                end
                SEL_DATA_A: begin
                    st_d.stg.vld = wdata[31];
                    st_d.stg.aux = wdata[8 +: AUX_W];
                    st_d.stg.sid = wdata[0 +: SID_W];
                end
                SEL_DATA_B: begin
                    st_d.stg.key  = wdata[16 +: RID_W];
                    st_d.stg.mask = wdata[0 +: RID_W];
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign commit_en    = commit_d;
    assign commit_entry = st_q.stg;
    assign stage        = st_q.stg;

    always_comb begin
        case (sel)
            SEL_CTRL:   rdata = {15'b0, st_q.act, 11'b0, st_q.idx};
            SEL_DATA_A: rdata = image_a(st_q.stg);
            SEL_DATA_B: rdata = image_b(st_q.stg);
            default:    rdata = '0;
        endcase
    end

endmodule

// File: rtl/rsm_table.sv
module rsm_table
    import rsm_pkg::*;
#(
    parameter int ENTRIES = 32
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_en,
    input  logic [IDX_FIELD_W-1:0] wr_idx,
    input  entry_t                 wr_entry,
    input  logic [IDX_FIELD_W-1:0] rd_idx,
    output entry_t [ENTRIES-1:0]   tbl,
    output entry_t                 rd_entry
);

    for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
        entry_t ent_d, ent_q;

        always_comb begin
            ent_d = ent_q;
            if (wr_en && (wr_idx == IDX_FIELD_W'(g))) begin
                ent_d = wr_entry;
            end
        end

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                ent_q <= '0;
            end else begin
                ent_q <= ent_d;
            end
        end

        assign tbl[g] = ent_q;
    end

    always_comb begin
        rd_entry = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (rd_idx == IDX_FIELD_W'(i)) begin
                rd_entry = tbl[i];
            end
        end
    end

endmodule

// File: rtl/rsm_match.sv
module rsm_match
    import rsm_pkg::*;
#(
    parameter int ENTRIES = 32
) (
    input  logic [RID_W-1:0]     rid,
    input  entry_t [ENTRIES-1:0] tbl,
    output result_t              res
);

    logic [ENTRIES-1:0] hit_vec;

    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
        assign hit_vec[g] = tbl[g].vld &&
                            (((rid ^ tbl[g].key) & tbl[g].mask) == '0);
    end

    always_comb begin
        res = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (hit_vec[i]) begin
                res.hit = 1'b1;
                res.sid = tbl[i].sid;
                res.aux = tbl[i].aux;
            end
        end
    end

endmodule

// File: rtl/reqid_stream_map.sv
module reqid_stream_map
    import rsm_pkg::*;
#(
    parameter int ENTRIES = 32
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_wr,
    input  logic [1:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    input  logic [15:0] lk_rid,
    output logic        lk_hit,
    output logic [5:0]  lk_sid,
    output logic [2:0]  lk_aux
);

    localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

    entry_t                 peek_entry;
    logic [IDX_FIELD_W-1:0] peek_idx;
    logic                   commit_en;
    logic [IDX_FIELD_W-1:0] commit_idx;
    entry_t                 commit_entry;
    entry_t                 stage_w;
    entry_t [ENTRIES-1:0]   tbl;
    result_t                res_d, res_q;

    rsm_regs u_regs (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr           (reg_wr),
        .addr         (reg_addr),
        .wdata        (reg_wdata),
        .peek_entry   (peek_entry),
        .peek_idx     (peek_idx),
        .commit_en    (commit_en),
        .commit_idx   (commit_idx),
        .commit_entry (commit_entry),
        .stage        (stage_w),
        .rdata        (reg_rdata)
    );

    rsm_table #(.ENTRIES(ENTRIES)) u_table (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (commit_en),
        .wr_idx   (commit_idx),
        .wr_entry (commit_entry),
        .rd_idx   (peek_idx),
        .tbl      (tbl),
        .rd_entry (peek_entry)
    );

    rsm_match #(.ENTRIES(ENTRIES)) u_match (
        .rid (lk_rid),
        .tbl (tbl),
        .res (res_d)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_q <= '0;
        end else begin
            res_q <= res_d;
        end
    end

    assign lk_hit = res_q.hit;
    assign lk_sid = res_q.sid;
    assign lk_aux = res_q.aux;

endmodule

// File: rtl/rsm_checker.sv
module rsm_checker
    import rsm_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input logic        reg_wr,
    input logic [1:0]  reg_addr,
    input logic [31:0] reg_rdata,
    input logic [15:0] lk_rid,
    input logic        lk_hit,
    input logic [5:0]  lk_sid,
    input logic [2:0]  lk_aux,
    input entry_t      stage
);

    logic [1:0] age;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            age <= '0;
        end else if (age != 2'd3) begin
            age <= age + 2'd1;
        end
    end

    assert_reset_clear_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (age == 2'd0) |-> (!lk_hit && reg_rdata == 32'd0));

    assert_stage_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_wr |=> $stable(stage));

    assert_data_a_rsvd_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == 2'd1) |-> (reg_rdata[30:11] == '0 && reg_rdata[7:6] == '0));

    assert_miss_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_hit |-> (lk_sid == '0 && lk_aux == '0));

    assert_one_cycle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (age == 2'd3 && lk_rid == $past(lk_rid) && !$past(reg_wr))
        |=> $stable({lk_hit, lk_sid, lk_aux}));

    assert_ctrl_rsvd_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == 2'd0) |-> (reg_rdata[31:17] == '0 && reg_rdata[15:5] == '0));

    assert_unused_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == 2'd3) |-> (reg_rdata == 32'd0));

endmodule

bind reqid_stream_map rsm_checker u_rsm_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_rdata (reg_rdata),
    .lk_rid    (lk_rid),
    .lk_hit    (lk_hit),
    .lk_sid    (lk_sid),
    .lk_aux    (lk_aux),
    .stage     (stage_w)
);

// File: tb/tb_reqid_stream_map.sv
module tb_reqid_stream_map;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [31:0] reg_wdata = 32'd0;
    logic [31:0] reg_rdata;
    logic [15:0] lk_rid = 16'd0;
    logic        lk_hit;
    logic [5:0]  lk_sid;
    logic [2:0]  lk_aux;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    reqid_stream_map dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .lk_rid    (lk_rid),
        .lk_hit    (lk_hit),
        .lk_sid    (lk_sid),
        .lk_aux    (lk_aux)
    );

    // {rid, hit, sid, aux}
    localparam logic [25:0] VEC [10] = '{
        {16'h0100, 1'b1, 6'd5,  3'd1},
        {16'h0101, 1'b0, 6'd0,  3'd0},
        {16'h02FF, 1'b1, 6'd9,  3'd2},
        {16'h0210, 1'b1, 6'd9,  3'd2},
        {16'h0307, 1'b1, 6'd63, 3'd7},
        {16'h0308, 1'b0, 6'd0,  3'd0},
        {16'hABCD, 1'b1, 6'd33, 3'd4},
        {16'h0400, 1'b0, 6'd0,  3'd0},
        {16'h0000, 1'b0, 6'd0,  3'd0},
        {16'hFFFF, 1'b0, 6'd0,  3'd0}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_addr  = a;
        reg_wdata = d;
        reg_wr    = 1'b1;
        @(negedge clk);
        reg_wr    = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic prog(input int idx, input logic [31:0] a, input logic [31:0] b);
        wr(2'd1, a);
        wr(2'd2, b);
        wr(2'd0, 32'(idx));
    endtask

    task automatic look(input logic [15:0] rid, output logic [9:0] r);
        @(negedge clk);
        lk_rid = rid;
        @(negedge clk);
        r = {lk_hit, lk_sid, lk_aux};
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [31:0] d;
        logic [9:0]  r;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        for (int a = 0; a < 4; a++) begin
            rd(2'(a), d);
            check("R1 reg reset", d, 32'd0);
        end
        look(16'h0000, r);
        check("R1 lookup after reset", {22'd0, r}, 32'd0);

        // Program the table (R3)
        prog(0,  32'h8000_0105, 32'h0100_FFFF);
        prog(1,  32'h8000_0209, 32'h0200_FF00);
        prog(2,  32'h8000_030C, 32'h0210_FFFF);
        prog(3,  32'h8000_073F, 32'h0300_FFF8);
        prog(5,  32'h0000_0007, 32'h0400_FFFF);
        prog(31, 32'h8000_0421, 32'hABCD_FFFF);

        // R2, R5, R11: read-action readback of entry 3
        wr(2'd1, 32'd0);
        wr(2'd2, 32'd0);
        wr(2'd0, 32'h0001_0003);
        rd(2'd0, d); check("R11 ctrl readback", d, 32'h0001_0003);
        rd(2'd1, d); check("R2 stage A loaded", d, 32'h8000_073F);
        rd(2'd2, d); check("R5 stage B loaded", d, 32'h0300_FFF8);

        // Vector walk: R3, R6, R7, R8
        for (int i = 0; i < 10; i++) begin
            look(VEC[i][25:10], r);
            check("R6/R7/R8 lookup vector", {22'd0, r}, {22'd0, VEC[i][9:0]});
        end

        // R4: reserved bits and stream ID truncation
        wr(2'd1, 32'hFFFF_FFFF);
        rd(2'd1, d); check("R4 reserved bits zero", d, 32'h8000_073F);
        wr(2'd1, 32'h8000_0047);
        rd(2'd1, d); check("R4 stream ID 6 bits", d, 32'h8000_0007);
        wr(2'd2, 32'h1234_5678);
        rd(2'd2, d); check("R5 stage B full width", d, 32'h1234_5678);

        // R9: same-cycle lookup sees old entry, next cycle sees new
        wr(2'd1, 32'h8000_0314);
        wr(2'd2, 32'h0500_FFFF);
        @(negedge clk);
        reg_addr  = 2'd0;
        reg_wdata = 32'd6;
        reg_wr    = 1'b1;
        lk_rid    = 16'h0500;
        @(negedge clk);
        reg_wr = 1'b0;
        check("R9 same-cycle lookup old entry", {31'd0, lk_hit}, 32'd0);
        @(negedge clk);
        check("R9 next-cycle lookup new entry", {22'd0, lk_hit, lk_sid, lk_aux},
              {22'd0, 1'b1, 6'd20, 3'd3});

        // R10: invalidate entry 0
        prog(0, 32'd0, 32'd0);
        look(16'h0100, r);
        check("R10 invalidated entry misses", {22'd0, r}, 32'd0);
        wr(2'd0, 32'h0001_0000);
        rd(2'd1, d); check("R10 entry A cleared", d, 32'd0);
        rd(2'd2, d); check("R10 entry B cleared", d, 32'd0);

        // R11: unused address
        wr(2'd1, 32'h8000_0102);
        wr(2'd3, 32'hFFFF_FFFF);
        rd(2'd3, d); check("R11 unused addr reads zero", d, 32'd0);
        rd(2'd1, d); check("R11 unused write ignored", d, 32'h8000_0102);
        rd(2'd0, d); check("R11 ctrl untouched", d, 32'h0001_0000);

        // R6/R7: zero-mask catch-all at index 30
        prog(30, 32'h8000_0001, 32'h0000_0000);
        look(16'h1234, r);
        check("R6 zero mask matches all", {22'd0, r}, {22'd0, 1'b1, 6'd1, 3'd0});
        look(16'hABCD, r);
        check("R7 lower index wins", {22'd0, r}, {22'd0, 1'b1, 6'd1, 3'd0});
        look(16'h0307, r);
        check("R7 entry 3 over entry 30", {22'd0, r}, {22'd0, 1'b1, 6'd63, 3'd7});

        finish_run();
    end

endmodule